// File: doc/BRIEF.md
# Nybble-Steered Bank Select Registers

This block is the register core of one expansion-bank controller that hangs off a 4-bit data bus. It claims four fixed bus addresses as ports 0 to 3. Through them the CPU programs three byte-wide registers:

- the number given to this bank (the assigned number);
- the number of the bank the CPU wants to reach (the selected number);
- an 8-bit chunk-enable mask.

Each byte arrives as two nybbles. A single steering flip-flop decides which half of the byte each nybble fills.

Many copies of the block sit side by side, one per bank, and all of them see every bus write. A copy counts as matched when its selected number equals its assigned number. Writes to the mask reach only the matched copy. A protect-mode write goes further: the matched copy loads the new mask, and every other copy clears those same bits from its own mask. This way no chunk is ever enabled in two banks at once.

The mask leaves the block as chunk enables. The block also outputs a hit flag for the current bus address. The init/normal mode flag is an input to the block.

Top module: `bsel_bank_core`

## Requirements
- R1: Reset clears the assigned number, the selected number, the mask and the steering flip-flop. The bank is therefore matched with `chunk_en` = 00h, and the next nybble written lands in bits 3:0.
- R2: Only the exact addresses 4000h (port 0), A000h (port 1), C000h (port 2) and E000h (port 3) are decoded. A write to any other address changes no register and does not move the steering. A read of any other address leaves `bus_rdata_oe` low and `bus_rdata` at 0.
- R3: A nybble write to port 0, 1 or 2 fills bits 3:0 when steering is low and bits 7:4 when steering is high, then toggles the steering. The target register changes only on the high write, which loads {high nybble, staged low nybble}.
- R4: Writing value 2 to port 3 returns the steering to low. Any other value written to port 3 leaves the steering and all registers unchanged.
- R5: A completed byte write to port 1 loads the selected number whatever the match state. `bank_match` then shows whether the selected number equals the assigned number.
- R6: A completed byte write to port 0 loads the mask only while matched. Otherwise the mask is unchanged.
- R7: In normal mode (`init_mode` = 0), a completed byte write to port 2 is protect-mode. A matched bank loads the byte as its mask. An unmatched bank clears each mask bit that is 1 in the byte.
- R8: With `init_mode` = 1, a completed byte write to port 2 loads the assigned number and leaves the mask unchanged.
- R9: While matched, a read of port 0 returns mask bits 3:0 and a read of port 1 returns mask bits 7:4, both with `bus_rdata_oe` = 1. While unmatched, these reads leave `bus_rdata_oe` = 0 and `bus_rdata` = 0.
- R10: A read of port 2 while matched returns local status {`init_mode`, 0 (bank answering, active low), 0, 1 (no interrupt, active low)}. While unmatched it is not driven. A read of port 3 is always driven with 1111b (global status, no bank interrupt pending).
- R11: `mem_hit` equals mask bit n, where n = `bus_addr`[15:13], so bit n enables the 8 KB chunk from n*2000h to n*2000h+1FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe, one cycle per nybble |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 4 | Write nybble |
| init_mode | input | 1 | 1 = init mode, 0 = normal mode |
| bus_rdata | output | 4 | Read nybble, 0 when not driven |
| bus_rdata_oe | output | 1 | Bank drives the read data |
| chunk_en | output | 8 | Chunk-enable mask |
| bank_match | output | 1 | Selected number equals assigned number |
| mem_hit | output | 1 | Chunk holding `bus_addr` is enabled |

## Verification
If the steering flip-flop is wrong, a nybble lands in the wrong half of its register. Because a byte lands only on its second write, the symptom shows up at the ports no earlier than that commit. It appears as a swapped or stale `chunk_en`, or as a wrong `bank_match` one cycle later. A wrong match, or a wrong choice between load, clear and hold, makes `chunk_en` diverge in the cycle after the commit. Readback and status then show the error through `bus_rdata_oe`. The stimulus deliberately interleaves commands, stray addresses and mode changes between the two halves of a byte, so that a mis-stepped steering flip-flop becomes visible.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  localparam int NYB_W  = 4;
  localparam int BYTE_W = 2 * NYB_W;
  localparam int NPORTS = 4;

  typedef enum logic [1:0] {
    PORT_MASK = 2'd0,
    PORT_SEL  = 2'd1,
    PORT_ASGN = 2'd2,
    PORT_CMD  = 2'd3
  } port_e;

  localparam logic [NYB_W-1:0] CMD_STEER_LOW = 4'd2;
  localparam logic [NYB_W-1:0] GLOBAL_STATUS = 4'b1111;

  // New mask of a bank after a protect-mode byte arrives.
  function automatic logic [BYTE_W-1:0] protect_merge(
      input logic [BYTE_W-1:0] own, input logic [BYTE_W-1:0] data, input logic matched);
    return matched ? data : (own & ~data);
  endfunction

  // Local status nybble: {init, answering_n, 0, irq_n}.
  function automatic logic [NYB_W-1:0] local_status(input logic init, input logic matched);
    return {init, ~matched, 1'b0, 1'b1};
  endfunction
endpackage

// File: rtl/bsel_decode.sv
module bsel_decode
  import bsel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [NPORTS-1:0][ADDR_W-1:0] PORT_ADDR = {16'hE000, 16'hC000, 16'hA000, 16'h4000}
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output port_e             idx
);
  logic [NPORTS-1:0] hits;

  for (genvar g = 0; g < NPORTS; g++) begin : g_cmp
    assign hits[g] = (addr == PORT_ADDR[g]);
  end

  always_comb begin
    idx = PORT_MASK;
    for (int i = 0; i < NPORTS; i++)
      if (hits[i]) idx = port_e'(i);
  end

  assign hit = |hits;
endmodule

// File: rtl/bsel_steer.sv
module bsel_steer
  import bsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_byte,
  input  logic              steer_clr,
  input  logic [NYB_W-1:0]  wdata,
  output logic              hi_sel,
  output logic              commit,
  output logic [BYTE_W-1:0] commit_byte
);
  logic [NYB_W-1:0] stage_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_sel   <= 1'b0;
      stage_lo <= '0;
    end else if (steer_clr) begin
      hi_sel   <= 1'b0;
    end else if (wr_byte) begin
      hi_sel   <= ~hi_sel;
      if (!hi_sel) stage_lo <= wdata;
    end
  end

  assign commit      = wr_byte & hi_sel;
  assign commit_byte = {wdata, stage_lo};
endmodule

// File: rtl/bsel_regs.sv
module bsel_regs
  import bsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  port_e             commit_port,
  input  logic [BYTE_W-1:0] commit_byte,
  input  logic              init_mode,
  output logic [BYTE_W-1:0] mask,
  output logic              matched
);
  logic [BYTE_W-1:0] asgn_num;
  logic [BYTE_W-1:0] sel_num;

  assign matched = (asgn_num == sel_num);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asgn_num <= '0;
      sel_num  <= '0;
      mask     <= '0;
    end else if (commit) begin
      unique case (commit_port)
        PORT_MASK: if (matched) mask <= commit_byte;
        PORT_SEL:  sel_num <= commit_byte;
        PORT_ASGN: begin
          if (init_mode) asgn_num <= commit_byte;
          else           mask     <= protect_merge(mask, commit_byte, matched);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bsel_bank_core.sv
module bsel_bank_core
  import bsel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [NPORTS-1:0][ADDR_W-1:0] PORT_ADDR = {16'hE000, 16'hC000, 16'hA000, 16'h4000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_wdata,
  input  logic              init_mode,
  output logic [3:0]        bus_rdata,
  output logic              bus_rdata_oe,
  output logic [7:0]        chunk_en,
  output logic              bank_match,
  output logic              mem_hit
);
  localparam int CHUNK_IDX_W = $clog2(BYTE_W);

  logic              port_hit;
  port_e             port_idx;
  logic              wr_byte;
  logic              steer_clr;
  logic              hi_sel;
  logic              commit;
  logic [BYTE_W-1:0] commit_byte;
  logic [BYTE_W-1:0] mask;
  logic              matched;

  bsel_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(bus_addr), .hit(port_hit), .idx(port_idx)
  );

  assign wr_byte   = bus_wr & port_hit & (port_idx != PORT_CMD);
  assign steer_clr = bus_wr & port_hit & (port_idx == PORT_CMD) & (bus_wdata == CMD_STEER_LOW);

  bsel_steer u_steer (
    .clk(clk), .rst_n(rst_n), .wr_byte(wr_byte), .steer_clr(steer_clr),
    .wdata(bus_wdata), .hi_sel(hi_sel), .commit(commit), .commit_byte(commit_byte)
  );

  bsel_regs u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_port(port_idx),
    .commit_byte(commit_byte), .init_mode(init_mode), .mask(mask), .matched(matched)
  );

  always_comb begin
    bus_rdata_oe = 1'b0;
    bus_rdata    = '0;
    if (bus_rd && port_hit) begin
      unique case (port_idx)
        PORT_MASK: begin bus_rdata_oe = matched; bus_rdata = matched ? mask[NYB_W-1:0] : '0; end
        PORT_SEL:  begin bus_rdata_oe = matched; bus_rdata = matched ? mask[BYTE_W-1:NYB_W] : '0; end
        PORT_ASGN: begin bus_rdata_oe = matched; bus_rdata = matched ? local_status(init_mode, matched) : '0; end
        PORT_CMD:  begin bus_rdata_oe = 1'b1;    bus_rdata = GLOBAL_STATUS; end
        default: ;
      endcase
    end
  end

  assign chunk_en   = mask;
  assign bank_match = matched;
  assign mem_hit    = mask[bus_addr[ADDR_W-1 -: CHUNK_IDX_W]];
endmodule

// File: rtl/bsel_bank_core_chk.sv
module bsel_bank_core_chk
  import bsel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              port_hit,
  input logic              bus_rdata_oe,
  input logic              wr_byte,
  input logic              steer_clr,
  input logic              hi_sel,
  input logic              commit,
  input port_e             port_idx,
  input logic [BYTE_W-1:0] commit_byte,
  input logic              init_mode,
  input logic              bank_match,
  input logic [BYTE_W-1:0] chunk_en
);
  a_r2_stray_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !port_hit |-> !bus_rdata_oe);

  a_r3_steer_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |=> hi_sel != $past(hi_sel));

  a_r4_steer_low: assert property (@(posedge clk) disable iff (!rst_n)
    steer_clr |=> !hi_sel);

  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && port_idx == PORT_MASK && bank_match) |=> chunk_en == $past(commit_byte));

  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && port_idx == PORT_MASK && !bank_match) |=> $stable(chunk_en));

  a_r7_protect_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && port_idx == PORT_ASGN && !init_mode && !bank_match)
      |=> (chunk_en & $past(commit_byte)) == '0);

  a_r8_init_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && port_idx == PORT_ASGN && init_mode) |=> $stable(chunk_en));
endmodule

bind bsel_bank_core bsel_bank_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_hit(port_hit), .bus_rdata_oe(bus_rdata_oe),
  .wr_byte(wr_byte), .steer_clr(steer_clr), .hi_sel(hi_sel), .commit(commit),
  .port_idx(port_idx), .commit_byte(commit_byte), .init_mode(init_mode),
  .bank_match(bank_match), .chunk_en(chunk_en)
);

// File: tb/tb_bsel_bank_core.sv
module tb_bsel_bank_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, init_mode = 1'b0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic       bus_rdata_oe, bank_match, mem_hit;
  logic [7:0] chunk_en;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bsel_bank_core dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .init_mode(init_mode), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .chunk_en(chunk_en), .bank_match(bank_match), .mem_hit(mem_hit)
  );

  typedef struct packed {
    logic wr; logic [15:0] addr; logic [3:0] data; logic init; logic [3:0] req;
    logic ck_rd; logic oe; logic [3:0] rd; logic [7:0] ch; logic m;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VT [NV] = '{
    '{1, 16'hE000, 4'h2, 0, 4, 0, 0, 4'h0, 8'h00, 1},  // R4 steer low
    '{1, 16'h4000, 4'h5, 0, 3, 0, 0, 4'h0, 8'h00, 1},  // R3 low half staged only
    '{1, 16'h4000, 4'hA, 0, 3, 0, 0, 4'h0, 8'hA5, 1},  // R3 commit
    '{0, 16'h4000, 4'h0, 0, 9, 1, 1, 4'h5, 8'hA5, 1},  // R9
    '{0, 16'hA000, 4'h0, 0, 9, 1, 1, 4'hA, 8'hA5, 1},  // R9
    '{0, 16'hC000, 4'h0, 0,10, 1, 1, 4'h1, 8'hA5, 1},  // R10
    '{0, 16'hE000, 4'h0, 0,10, 1, 1, 4'hF, 8'hA5, 1},  // R10
    '{1, 16'hA000, 4'h3, 0, 5, 0, 0, 4'h0, 8'hA5, 1},  // R5
    '{1, 16'hA000, 4'h0, 0, 5, 0, 0, 4'h0, 8'hA5, 0},  // R5 selected = 03
    '{0, 16'h4000, 4'h0, 0, 9, 1, 0, 4'h0, 8'hA5, 0},  // R9 unmatched silent
    '{0, 16'hC000, 4'h0, 0,10, 1, 0, 4'h0, 8'hA5, 0},  // R10
    '{0, 16'hE000, 4'h0, 0,10, 1, 1, 4'hF, 8'hA5, 0},  // R10
    '{1, 16'h4000, 4'hF, 0, 6, 0, 0, 4'h0, 8'hA5, 0},  // R6
    '{1, 16'h4000, 4'hF, 0, 6, 0, 0, 4'h0, 8'hA5, 0},  // R6 unmatched hold
    '{1, 16'hC000, 4'h3, 0, 7, 0, 0, 4'h0, 8'hA5, 0},  // R7
    '{1, 16'hC000, 4'h0, 0, 7, 0, 0, 4'h0, 8'hA4, 0},  // R7 clear bits 03
    '{1, 16'hC000, 4'h3, 1, 8, 0, 0, 4'h0, 8'hA4, 0},  // R8
    '{1, 16'hE000, 4'h7, 1, 4, 0, 0, 4'h0, 8'hA4, 0},  // R4 other command
    '{1, 16'hC000, 4'h0, 1, 8, 0, 0, 4'h0, 8'hA4, 1},  // R8 assigned = 03
    '{0, 16'h4000, 4'h0, 1, 9, 1, 1, 4'h4, 8'hA4, 1},  // R9
    '{0, 16'hA000, 4'h0, 1, 9, 1, 1, 4'hA, 8'hA4, 1},  // R9
    '{0, 16'hC000, 4'h0, 1,10, 1, 1, 4'h9, 8'hA4, 1},  // R10 init bit
    '{1, 16'hC000, 4'h1, 0, 7, 0, 0, 4'h0, 8'hA4, 1},  // R7
    '{1, 16'hC000, 4'hC, 0, 7, 0, 0, 4'h0, 8'hC1, 1},  // R7 matched load
    '{1, 16'h4000, 4'hE, 0, 3, 0, 0, 4'h0, 8'hC1, 1},  // R3
    '{1, 16'hE000, 4'h2, 0, 4, 0, 0, 4'h0, 8'hC1, 1},  // R4 mid-byte
    '{1, 16'h4000, 4'h3, 0, 3, 0, 0, 4'h0, 8'hC1, 1},  // R3
    '{1, 16'h4000, 4'h6, 0, 3, 0, 0, 4'h0, 8'h63, 1},  // R3
    '{1, 16'h4001, 4'hF, 0, 2, 0, 0, 4'h0, 8'h63, 1},  // R2
    '{1, 16'h8000, 4'hF, 0, 2, 0, 0, 4'h0, 8'h63, 1},  // R2
    '{0, 16'h4001, 4'h0, 0, 2, 1, 0, 4'h0, 8'h63, 1},  // R2
    '{1, 16'h4000, 4'h1, 0, 2, 0, 0, 4'h0, 8'h63, 1},  // R2 steering unmoved
    '{1, 16'h4000, 4'h8, 0, 2, 0, 0, 4'h0, 8'h81, 1},  // R2
    '{0, 16'hBFFF, 4'h0, 0, 2, 1, 0, 4'h0, 8'h81, 1}   // R2
  };

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic [15:0] a, input logic [3:0] d, input logic im);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; init_mode = im; bus_wr = wr; bus_rd = !wr;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(1, "reset chunk_en", chunk_en, 8'h00);          // R1
    chk(1, "reset match", {7'd0, bank_match}, 8'h01);  // R1
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op(VT[i].wr, VT[i].addr, VT[i].data, VT[i].init);
      chk(VT[i].req, $sformatf("row %0d chunk_en", i), chunk_en, VT[i].ch);
      chk(VT[i].req, $sformatf("row %0d match", i), {7'd0, bank_match}, {7'd0, VT[i].m});
      if (VT[i].ck_rd) begin
        chk(VT[i].req, $sformatf("row %0d oe", i), {7'd0, bus_rdata_oe}, {7'd0, VT[i].oe});
        chk(VT[i].req, $sformatf("row %0d rdata", i), {4'd0, bus_rdata}, {4'd0, VT[i].rd});
      end
    end

    // R11: mask is 81h, so only chunks 0 and 7 hit
    bus_rd = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      bus_addr = 16'(c * 16'h2000 + 16'h0123);
      #1;
      chk(11, $sformatf("mem_hit chunk %0d", c), {7'd0, mem_hit}, {7'd0, (c == 0 || c == 7)});
    end

    // R1: reset in the middle of a byte, steering must come back low
    op(1, 16'h4000, 4'hF, 0);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #2;
    chk(1, "mid reset chunk_en", chunk_en, 8'h00);
    chk(1, "mid reset match", {7'd0, bank_match}, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    op(1, 16'h4000, 4'h9, 0);
    op(1, 16'h4000, 4'h6, 0);
    chk(1, "steering low after reset", chunk_en, 8'h69);
    op(0, 16'hA000, 4'h0, 0);
    chk(1, "readback after reset", {4'd0, bus_rdata}, 8'h06);

    finish_run();
  end
endmodule